// File: doc/BRIEF.md
# SPI Response Packet Fetcher

This block is the host side of a polled SPI link. It acts as an SPI master and reads a framed response packet from a slave target that cannot start a transfer on its own. Every byte the block sends is a dummy zero, so each byte time brings one byte back from the target. A fetch starts with a single-cycle `start` pulse. The block then polls until the target returns the sync byte, or until the retry budget is used up.

Once the sync byte arrives, the block checks the packet-type byte and reads a two-byte length. It limits that length to a configured maximum. It then hands each payload byte to the consumer over a valid/ready byte port. Last, it reads a two-byte checksum and compares it with a CRC it computes over the frame. The fetch ends in exactly one of three outcomes: a completion pulse that carries a CRC-mismatch flag, a timeout pulse, or a framing-error pulse.

Top module: `spi_resp_fetcher`

## Requirements
- R1: The bus runs in SPI mode 3. `sclk` is high whenever `cs_n` is high. `mosi` is always 0. Each byte is eight SCLK cycles, and each SCLK half period lasts CLK_DIV clocks. `miso` is sampled on the rising SCLK edges, most significant bit first.
- R2: A `start` pulse seen while idle sets `busy` high and `cs_n` low one clock later. Both stay that way until the result pulse, and `busy` and `cs_n` return to idle in that same cycle. A `start` pulse while `busy` is high has no effect.
- R3: While hunting for sync, any byte other than 0x5A is treated as "no data yet" and counts as one retry. When MAX_RETRY such bytes have been read without a sync, the block pulses `timeout` and goes idle, having read exactly MAX_RETRY bytes.
- R4: The byte after 0x5A must be 0xA4. Any other value makes the block pulse `frame_err` and go idle.
- R5: The two length bytes come least significant byte first. A length above MAX_LEN is replaced by MAX_LEN, and exactly that many payload bytes are read.
- R6: Each payload byte appears on `pl_data` with `pl_valid` high. It is held unchanged until `pl_ready` is seen high. The next SPI byte is not started until the current one has been accepted.
- R7: A length of zero skips the payload and goes straight to the checksum.
- R8: The CRC trailer comes least significant byte first. The computed CRC uses polynomial 0x1021 with initial value 0, processed MSB first. It covers the sync byte, the type byte, both length bytes and every payload byte read. `crc_err` is 1 during the `done` pulse exactly when the computed value and the trailer differ.
- R9: Each fetch produces exactly one single-cycle pulse on exactly one of `done`, `timeout` and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a fetch |
| busy | output | 1 | High while a fetch is in progress |
| done | output | 1 | Pulse: packet fully read |
| timeout | output | 1 | Pulse: sync not found within the retry budget |
| frame_err | output | 1 | Pulse: wrong packet-type byte |
| crc_err | output | 1 | Checksum mismatch, valid with `done` |
| sclk | output | 1 | SPI clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Master data out (always 0) |
| miso | input | 1 | Slave data in |
| pl_data | output | 8 | Payload byte |
| pl_valid | output | 1 | Payload byte available |
| pl_ready | input | 1 | Consumer accepts the payload byte |

## Verification
`busy` and `cs_n` are due one clock after `start`. Each byte then takes 16·CLK_DIV clocks plus one clock to launch it. The result pulse, `crc_err` and the return of `busy` low all fall one clock after the last rising SCLK edge. Payload bytes wait on `pl_ready` for as long as it is held low, so byte timing depends on the consumer. For this reason the bench does not count cycles to a fixed end time. It samples on falling clock edges and checks `busy` on every cycle until the result pulse. It then expects the idle state in that same sample. The number of bytes polled is checked by counting falling SCLK edges while `cs_n` is low.

// File: rtl/spi_fetch_pkg.sv
package spi_fetch_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h5A;
  localparam logic [7:0] TYPE_BYTE = 8'hA4;

  typedef enum logic [3:0] {
    S_IDLE, S_HUNT, S_TYPE, S_LEN0, S_LEN1, S_PAY, S_OUT, S_CRC0, S_CRC1
  } fetch_state_t;

  // One byte of CRC-16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction
endpackage

// File: rtl/spi_mode3_shifter.sv
module spi_mode3_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       miso,
  output logic       sclk,
  output logic       idle,
  output logic       rx_done,
  output logic [7:0] rx_byte
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;

  assign idle = !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b1;
      shreg   <= '0;
      rx_done <= 1'b0;
      rx_byte <= '0;
    end else begin
      rx_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt == DW'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        if (sclk) begin
          sclk <= 1'b0;
        end else begin
          sclk  <= 1'b1;
          shreg <= {shreg[6:0], miso};
          if (bit_cnt == 3'd7) begin
            active  <= 1'b0;
            rx_done <= 1'b1;
            rx_byte <= {shreg[6:0], miso};
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  // R1: the shift engine is never left with SCLK low while idle
  p_sclk_high_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !active |-> sclk);
  // R1: a byte completes only on a rising SCLK edge
  p_done_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (sclk && $rose(sclk)));
endmodule

// File: rtl/spi_fetch_crc.sv
module spi_fetch_crc import spi_fetch_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 16'h0000;
    else if (en)    crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/spi_resp_fetcher.sv
module spi_resp_fetcher import spi_fetch_pkg::*; #(
  parameter int CLK_DIV   = 4,
  parameter int MAX_LEN   = 64,
  parameter int MAX_RETRY = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic       frame_err,
  output logic       crc_err,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso,
  output logic [7:0] pl_data,
  output logic       pl_valid,
  input  logic       pl_ready
);
  localparam int RW = $clog2(MAX_RETRY + 1);

  fetch_state_t  st;
  logic [RW-1:0] retry;
  logic [15:0]   eff_len, pay_cnt, raw_len, crc_val;
  logic [7:0]    len_lo, crc_lo, rx_byte;
  logic          rx_done, sh_idle, go, reading, crc_clr, crc_en;

  assign mosi    = 1'b0;
  assign reading = (st == S_HUNT) || (st == S_TYPE) || (st == S_LEN0) || (st == S_LEN1) ||
                   (st == S_PAY)  || (st == S_CRC0) || (st == S_CRC1);
  assign go      = reading && sh_idle && !rx_done;
  assign raw_len = {rx_byte, len_lo};
  assign crc_clr = (st == S_IDLE) && start;
  assign crc_en  = rx_done && (((st == S_HUNT) && (rx_byte == SYNC_BYTE)) || (st == S_TYPE) ||
                               (st == S_LEN0) || (st == S_LEN1) || (st == S_PAY));

  spi_mode3_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .miso(miso), .sclk(sclk),
    .idle(sh_idle), .rx_done(rx_done), .rx_byte(rx_byte)
  );

  spi_fetch_crc u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(rx_byte), .crc(crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      timeout   <= 1'b0;
      frame_err <= 1'b0;
      crc_err   <= 1'b0;
      retry     <= '0;
      eff_len   <= '0;
      pay_cnt   <= '0;
      len_lo    <= '0;
      crc_lo    <= '0;
      pl_data   <= '0;
      pl_valid  <= 1'b0;
    end else begin
      done      <= 1'b0;
      timeout   <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_HUNT;
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          retry   <= '0;
          crc_err <= 1'b0;
        end
        S_HUNT: if (rx_done) begin
          if (rx_byte == SYNC_BYTE) begin
            st <= S_TYPE;
          end else if (retry == RW'(MAX_RETRY - 1)) begin
            st <= S_IDLE; busy <= 1'b0; cs_n <= 1'b1; timeout <= 1'b1;
          end else begin
            retry <= retry + RW'(1);
          end
        end
        S_TYPE: if (rx_done) begin
          if (rx_byte == TYPE_BYTE) st <= S_LEN0;
          else begin
            st <= S_IDLE; busy <= 1'b0; cs_n <= 1'b1; frame_err <= 1'b1;
          end
        end
        S_LEN0: if (rx_done) begin
          len_lo <= rx_byte;
          st     <= S_LEN1;
        end
        S_LEN1: if (rx_done) begin
          eff_len <= (raw_len > 16'(MAX_LEN)) ? 16'(MAX_LEN) : raw_len;
          pay_cnt <= '0;
          st      <= (raw_len == 16'd0) ? S_CRC0 : S_PAY;
        end
        S_PAY: if (rx_done) begin
          pl_data  <= rx_byte;
          pl_valid <= 1'b1;
          st       <= S_OUT;
        end
        S_OUT: if (pl_ready) begin
          pl_valid <= 1'b0;
          pay_cnt  <= pay_cnt + 16'd1;
          st       <= (16'(pay_cnt + 16'd1) == eff_len) ? S_CRC0 : S_PAY;
        end
        S_CRC0: if (rx_done) begin
          crc_lo <= rx_byte;
          st     <= S_CRC1;
        end
        S_CRC1: if (rx_done) begin
          crc_err <= (crc_val != {rx_byte, crc_lo});
          done    <= 1'b1;
          busy    <= 1'b0;
          cs_n    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: bus idles with SCLK high whenever the target is deselected
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk);
  // R2: chip select tracks busy for the whole fetch
  p_cs_busy_r2: assert property (@(posedge clk) disable iff (rst) busy |-> !cs_n);
  // R3: retry count stays inside the budget
  p_retry_bound_r3: assert property (@(posedge clk) disable iff (rst) retry < RW'(MAX_RETRY));
  // R5: the delivered count never passes the clamped length
  p_len_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (eff_len <= 16'(MAX_LEN)) && (pay_cnt <= eff_len));
  // R6: an offered byte is held until taken
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data)));
  // R6: no SPI traffic while a payload byte waits
  p_no_shift_wait_r6: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> sh_idle);
  // R9: at most one result per cycle, and a result ends the fetch
  p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, frame_err}));
  p_result_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (done || timeout || frame_err) |-> (!busy && cs_n));
endmodule

// File: tb/spi_resp_fetcher_bench.sv
module spi_resp_fetcher_bench;
  localparam int CLK_DIV = 2, MAX_LEN = 8, MAX_RETRY = 16;

  logic clk = 0, rst = 1, start = 0, miso = 1, pl_ready = 1;
  logic busy, done, timeout, frame_err, crc_err, sclk, cs_n, mosi, pl_valid;
  logic [7:0] pl_data;

  spi_resp_fetcher #(.CLK_DIV(CLK_DIV), .MAX_LEN(MAX_LEN), .MAX_RETRY(MAX_RETRY)) u_spi_resp_fetcher (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .timeout(timeout),
    .frame_err(frame_err), .crc_err(crc_err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, falls = 0, results = 0;
  logic [7:0] slave_q[$], got_q[$], exp_q[$];
  logic [7:0] cur = 0;
  int bitn = 0;
  bit ready_toggle = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  // Target model: drives the next bit on each falling SCLK edge, MSB first
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) bitn = 0;
    else begin
      if (bitn == 0) cur = (slave_q.size() > 0) ? slave_q.pop_front() : 8'h00;
      miso = cur[7 - bitn];
      falls++;
      bitn = (bitn + 1) % 8;
    end
  end

  always @(posedge clk) if (!rst && pl_valid && pl_ready) got_q.push_back(pl_data);

  // Per-cycle bus checks and consumer drive
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(!cs_n || sclk, "R1 sclk idle high", sclk, 1);
      check(mosi == 1'b0, "R1 mosi dummy zero", mosi, 0);
      if (done || timeout || frame_err) results++;
      if (pl_valid && !pl_ready) begin end
    end
    pl_ready <= ready_toggle ? cycles[1] : 1'b1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Runs one fetch and returns outcome: 0 done, 1 timeout, 2 frame_err
  task automatic run(output int kind, output bit cerr, output int nfalls, input bit extra_start);
    int n = 0;
    got_q.delete();
    falls = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy && !cs_n, "R2 busy and cs after start", {busy, cs_n}, 2'b10);
    kind = -1;
    while (kind < 0) begin
      @(negedge clk);
      n++;
      if (extra_start && n == 40) start = 1;
      if (extra_start && n == 41) start = 0;
      if (done) kind = 0; else if (timeout) kind = 1; else if (frame_err) kind = 2;
      if (kind >= 0) check(!busy && cs_n, "R2 idle at result", {busy, cs_n}, 2'b01);
      else check(busy, "R2 busy held", busy, 1);
      if (n > 20000) kind = 9;
    end
    cerr = crc_err;
    nfalls = falls;
    repeat (4) @(negedge clk);
    slave_q.delete();
  endtask

  // Builds a packet; payload has plen_sent bytes, header says hdr_len
  task automatic build(input int lead, input int hdr_len, input int plen_sent, input bit bad);
    logic [15:0] c = 0;
    logic [7:0] p[$];
    int use_n;
    slave_q.delete(); exp_q.delete();
    for (int i = 0; i < lead; i++) slave_q.push_back(8'h00);
    for (int i = 0; i < plen_sent; i++) p.push_back(8'((i * 37 + 11) ^ hdr_len));
    slave_q.push_back(8'h5A); slave_q.push_back(8'hA4);
    slave_q.push_back(hdr_len[7:0]); slave_q.push_back(hdr_len[15:8]);
    c = crc_b(c, 8'h5A); c = crc_b(c, 8'hA4); c = crc_b(c, hdr_len[7:0]); c = crc_b(c, hdr_len[15:8]);
    use_n = (hdr_len > MAX_LEN) ? MAX_LEN : hdr_len;
    foreach (p[i]) begin
      slave_q.push_back(p[i]);
      if (i < use_n) begin exp_q.push_back(p[i]); c = crc_b(c, p[i]); end
    end
    if (bad) c = c ^ 16'h0100;
    slave_q.push_back(c[7:0]); slave_q.push_back(c[15:8]);
  endtask

  task automatic cmp_payload(input string tag);
    check(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
  endtask

  initial begin
    int kind, nf, r0;
    bit ce;
    repeat (4) @(negedge clk);
    check(!busy && cs_n && sclk && !pl_valid && !done, "reset state",
          {busy, cs_n, sclk, pl_valid, done}, 5'b01100);
    rst = 0;
    @(negedge clk);

    // R3/R5/R8: good packet after two idle bytes, extra start ignored (R2)
    build(2, 3, 3, 0);
    r0 = results;
    run(kind, ce, nf, 1);
    check(kind == 0 && !ce, "R8 good packet done", {kind[3:0], ce}, 5'b00000);
    check(results - r0 == 1, "R9 single result (R2 extra start)", results - r0, 1);
    cmp_payload("R5 payload bytes");

    // R6: slow consumer
    ready_toggle = 1;
    build(0, 6, 6, 0);
    run(kind, ce, nf, 0);
    check(kind == 0 && !ce, "R6 backpressure done", {kind[3:0], ce}, 5'b00000);
    cmp_payload("R6 payload under backpressure");
    ready_toggle = 0;

    // R8: corrupted trailer
    build(1, 4, 4, 1);
    run(kind, ce, nf, 0);
    check(kind == 0 && ce, "R8 crc mismatch flagged", {kind[3:0], ce}, 5'b00001);

    // R7: zero length
    build(0, 0, 0, 0);
    run(kind, ce, nf, 0);
    check(kind == 0 && !ce, "R7 empty payload", {kind[3:0], ce}, 5'b00000);
    check(got_q.size() == 0, "R7 no payload out", got_q.size(), 0);
    check(nf == 6 * 8, "R7 bytes read", nf, 48);

    // R5: length above maximum is clamped, LSB-first length 0x010A
    build(0, 266, 10, 0);
    run(kind, ce, nf, 0);
    check(kind == 0, "R5 clamp ends in done", kind, 0);
    check(nf == (6 + MAX_LEN) * 8, "R5 clamped byte count", nf, (6 + MAX_LEN) * 8);
    cmp_payload("R5 clamped payload");

    // R4: wrong type byte
    slave_q.delete();
    slave_q.push_back(8'h00); slave_q.push_back(8'h5A); slave_q.push_back(8'h33);
    r0 = results;
    run(kind, ce, nf, 0);
    check(kind == 2, "R4 framing error", kind, 2);
    check(nf == 3 * 8, "R4 stops after type byte", nf, 24);
    check(results - r0 == 1, "R9 one result on framing error", results - r0, 1);

    // R3: no sync ever, non-zero junk also ignored
    slave_q.delete();
    slave_q.push_back(8'hA4); slave_q.push_back(8'hFF);
    run(kind, ce, nf, 0);
    check(kind == 1, "R3 timeout", kind, 1);
    check(nf == MAX_RETRY * 8, "R3 polled byte count", nf, MAX_RETRY * 8);

    // R3: sync on the last allowed poll still succeeds
    build(MAX_RETRY - 1, 1, 1, 0);
    run(kind, ce, nf, 0);
    check(kind == 0 && !ce, "R3 sync on last retry", {kind[3:0], ce}, 5'b00000);
    cmp_payload("R3 payload after late sync");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule